// File: doc/BRIEF.md
# Multicart Outer Register Write Decoder

This block sits between the CPU write bus of a multi-game cartridge and its inner bank-switching controller. It keeps eight 8-bit outer registers that select the game block and the extended banking. Writes in the low page (0x5000-0x5FFF) update registers 0-3, but only when one address bit is set. A 3-bit switch position picks that bit. Writes in the high page (0x8000-0xFFFF) go to one of three places: a 2-bit discrete CHR latch, the extended registers 4-7, or the inner controller's command/data port and IRQ port.

The decision for each high-page write is made in priority order. The latch mode of register 0 comes first. Next comes the extended-register capture at 0x8001, which uses the inner controller's current command value. All remaining writes are forwarded, split at 0xC000 between the command port and the IRQ port. A board-variant input makes every low-page write clear the mode field of register 0 while extended banking is on. A CHR-RAM board input enables a data swap on one command value. A soft reset steps the switch position, so repeated resets try every position. A power-on reset sets the position back to zero.

Forwarded writes appear on the inner-port outputs as a one-cycle strobe, together with the address and the data, in the cycle after the write.

Top module: `mc_outer_decoder`

## Requirements
- R1: After power-on reset, registers 0-3 read 0x00, registers 4-7 read 0xFF, the switch position is 0, the CHR latch is 0 and neither inner strobe is active. Register i is `outer_regs[8*i+7:8*i]`.
- R2: A soft reset pulse gives the registers and the latch their R1 values and adds one to the switch position, modulo 8.
- R3: A write with address bits 15:12 = 0x5 stores the data in register `addr[1:0]` when address bit (4 + switch position) is 1. Otherwise it changes nothing. Writes to 0x0000-0x4FFF and 0x6000-0x7FFF change no register and strobe no port.
- R4: With `variant_a` = 1, after any low-page write, bits 2:0 of register 0 are cleared if bit 1 of the resulting register 3 is set. With `variant_a` = 0, no clearing takes place.
- R5: A write to exactly 0x8001 while register 3 bit 1 and `inner_cmd` bit 3 are both 1 (and R8 does not apply) stores the data in register 4 + `inner_cmd[1:0]`. No inner strobe is raised.
- R6: Any other high-page write outside R8 raises `cmd_we` if the address is below 0xC000, and raises `irq_we` if it is at or above 0xC000.
- R7: With `chr_ram_board` = 1, data 0x46 written to exactly 0x8000 is forwarded as 0x47, and 0x47 is forwarded as 0x46. All other data values and addresses, and boards with the input at 0, forward the data unchanged.
- R8: When register 0 bits 6:5 equal 2'b10, a high-page write only loads the CHR latch. The latch takes `data[1:0]` if register 0 bit 4 is 0, and takes 0 if bit 4 is 1. No inner strobe is raised.
- R9: A forwarded write shows its strobe, `inner_addr` and `inner_data` for exactly one cycle, starting in the cycle after the write. At most one strobe is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-on reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset pulse, steps the switch position |
| variant_a | input | 1 | Board variant that clears the mode field |
| chr_ram_board | input | 1 | Enables the command data swap |
| wr | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| data | input | 8 | CPU write data |
| inner_cmd | input | 8 | Current command value of the inner controller |
| outer_regs | output | 64 | Outer registers 0-7, register i at bits 8i+7:8i |
| switch_pos | output | 3 | Current switch position |
| chr_latch | output | 2 | Discrete CHR latch |
| cmd_we | output | 1 | Command/data port write strobe |
| irq_we | output | 1 | IRQ port write strobe |
| inner_addr | output | 16 | Address of the forwarded write |
| inner_data | output | 8 | Data of the forwarded write |

## Verification
The case that is hardest to reach from the ports is a low-page write at a non-zero switch position. A bit that opens the registers at one position must be ignored at the next. The bench gets there by issuing soft resets: it checks that address bit 5 writes after one step while bit 4 is ignored, and that eight steps bring the position back to zero. The extended-register capture needs register 3 to be loaded first through the low page, with the command input held at a value that has bit 3 set. The variant clearing needs the mode field to be written before register 3 enables extended banking.

// File: rtl/mc_outer_pkg.sv
package mc_outer_pkg;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_LOW,
        WK_LATCH,
        WK_EXT,
        WK_CMD,
        WK_IRQ
    } wr_kind_e;

endpackage

// File: rtl/mc_wr_classify.sv
module mc_wr_classify
    import mc_outer_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SW_W    = 3,
    parameter int SW_BASE = 4
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SW_W-1:0]   sw,
    input  logic              latch_mode,
    input  logic              ext_ok,
    output wr_kind_e          kind,
    output logic              low_hit
);
    localparam int NTAP = 1 << SW_W;

    logic [NTAP-1:0] taps;
    logic            is_low, is_high, is_ext_addr;

    assign taps        = addr[SW_BASE +: NTAP] >> sw;
    assign low_hit     = taps[0];
    assign is_low      = (addr[ADDR_W-1 -: 4] == 4'h5);
    assign is_high     = addr[ADDR_W-1];
    assign is_ext_addr = (addr == ADDR_W'(16'h8001));

    always_comb begin
        kind = WK_NONE;
        if (wr) begin
            if (is_low)                          kind = WK_LOW;
            else if (is_high && latch_mode)      kind = WK_LATCH;
            else if (is_high && is_ext_addr && ext_ok) kind = WK_EXT;
            else if (is_high && !addr[ADDR_W-2]) kind = WK_CMD;
            else if (is_high)                    kind = WK_IRQ;
        end
    end
endmodule

// File: rtl/mc_data_quirk.sv
module mc_data_quirk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic at_port;
    assign at_port = en && (addr == ADDR_W'(16'h8000));

    always_comb begin
        dout = din;
        if (at_port && din == DATA_W'(8'h46))      dout = DATA_W'(8'h47);
        else if (at_port && din == DATA_W'(8'h47)) dout = DATA_W'(8'h46);
    end
endmodule

// File: rtl/mc_outer_decoder.sv
module mc_outer_decoder
    import mc_outer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int NREG   = 8,
    parameter int SW_W   = 3,
    parameter int LAT_W  = 2
) (
    input  logic                   clk,
    input  logic                   pwr_rst_n,
    input  logic                   soft_rst,
    input  logic                   variant_a,
    input  logic                   chr_ram_board,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      data,
    input  logic [DATA_W-1:0]      inner_cmd,
    output logic [NREG*DATA_W-1:0] outer_regs,
    output logic [SW_W-1:0]        switch_pos,
    output logic [LAT_W-1:0]       chr_latch,
    output logic                   cmd_we,
    output logic                   irq_we,
    output logic [ADDR_W-1:0]      inner_addr,
    output logic [DATA_W-1:0]      inner_data
);
    localparam int IDX_W    = $clog2(NREG);
    localparam int HALF     = NREG / 2;
    localparam int SEL_W    = $clog2(HALF);
    localparam int MODE_REG = 0;
    localparam int CTRL_REG = HALF - 1;

    typedef logic [NREG-1:0][DATA_W-1:0] regs_t;

    typedef struct packed {
        regs_t             regs;
        logic [SW_W-1:0]   sw;
        logic [LAT_W-1:0]  latch;
        logic              cmd_we;
        logic              irq_we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } state_t;

    function automatic regs_t init_regs();
        regs_t r;
        for (int i = 0; i < NREG; i++)
            r[i] = (i < HALF) ? '0 : '1;
        return r;
    endfunction

    state_t            s_d, s_q;
    wr_kind_e          kind;
    logic              low_hit, latch_mode, ext_ok;
    logic [DATA_W-1:0] fwd_data;
    logic [IDX_W-1:0]  low_idx, ext_idx;

    assign latch_mode = s_q.regs[MODE_REG][6] && !s_q.regs[MODE_REG][5];
    assign ext_ok     = s_q.regs[CTRL_REG][1] && inner_cmd[3];
    assign low_idx    = IDX_W'(addr[SEL_W-1:0]);
    assign ext_idx    = IDX_W'(HALF) + IDX_W'(inner_cmd[SEL_W-1:0]);

    mc_wr_classify #(.ADDR_W(ADDR_W), .SW_W(SW_W), .SW_BASE(4)) i_classify (
        .wr         (wr),
        .addr       (addr),
        .sw         (s_q.sw),
        .latch_mode (latch_mode),
        .ext_ok     (ext_ok),
        .kind       (kind),
        .low_hit    (low_hit)
    );

    mc_data_quirk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_quirk (
        .en   (chr_ram_board),
        .addr (addr),
        .din  (data),
        .dout (fwd_data)
    );

    always_comb begin
        s_d        = s_q;
        s_d.cmd_we = 1'b0;
        s_d.irq_we = 1'b0;
        if (soft_rst) begin
            s_d.regs  = init_regs();
            s_d.sw    = s_q.sw + 1'b1;
            s_d.latch = '0;
        end else begin
            unique case (kind)
                WK_LOW: begin
                    if (low_hit)
                        s_d.regs[low_idx] = data;
                    if (variant_a && s_d.regs[CTRL_REG][1])
                        s_d.regs[MODE_REG][2:0] = 3'b000;
                end
                WK_LATCH: begin
                    s_d.latch = s_q.regs[MODE_REG][4] ? '0 : data[LAT_W-1:0];
                end
                WK_EXT: begin
                    s_d.regs[ext_idx] = data;
                end
                WK_CMD: begin
                    s_d.cmd_we = 1'b1;
                    s_d.addr   = addr;
                    s_d.data   = fwd_data;
                end
                WK_IRQ: begin
                    s_d.irq_we = 1'b1;
                    s_d.addr   = addr;
                    s_d.data   = data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!pwr_rst_n) begin
            s_q        <= '0;
            s_q.regs   <= init_regs();
        end else begin
            s_q <= s_d;
        end
    end

    assign outer_regs = s_q.regs;
    assign switch_pos = s_q.sw;
    assign chr_latch  = s_q.latch;
    assign cmd_we     = s_q.cmd_we;
    assign irq_we     = s_q.irq_we;
    assign inner_addr = s_q.addr;
    assign inner_data = s_q.data;

    // R2
    sw_step_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        soft_rst |=> s_q.sw == $past(s_q.sw) + 1'b1);

    // R2
    soft_init_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        soft_rst |=> (s_q.regs == init_regs()) && (s_q.latch == '0));

    // R3
    low_no_fwd_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr && !soft_rst && addr[ADDR_W-1 -: 4] == 4'h5) |=> !cmd_we && !irq_we);

    // R8
    latch_no_fwd_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr && !soft_rst && addr[ADDR_W-1] && latch_mode) |=> !cmd_we && !irq_we);

    // R5
    ext_store_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr && !soft_rst && !latch_mode && ext_ok && addr == ADDR_W'(16'h8001))
        |=> !cmd_we && s_q.regs[$past(ext_idx)] == $past(data));

    // R6
    fwd_strobe_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr && !soft_rst && addr[ADDR_W-1] && !latch_mode
         && !(ext_ok && addr == ADDR_W'(16'h8001)))
        |=> (cmd_we != irq_we) && inner_addr == $past(addr));

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        $onehot0({cmd_we, irq_we}));
endmodule

// File: tb/test_mc_outer_decoder.sv
module test_mc_outer_decoder;
    logic        clk = 1'b0;
    logic        pwr_rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        variant_a = 1'b0;
    logic        chr_ram_board = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic [7:0]  inner_cmd = '0;
    logic [63:0] outer_regs;
    logic [2:0]  switch_pos;
    logic [1:0]  chr_latch;
    logic        cmd_we, irq_we;
    logic [15:0] inner_addr;
    logic [7:0]  inner_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mc_outer_decoder i_mc_outer_decoder (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .soft_rst(soft_rst),
        .variant_a(variant_a), .chr_ram_board(chr_ram_board),
        .wr(wr), .addr(addr), .data(data), .inner_cmd(inner_cmd),
        .outer_regs(outer_regs), .switch_pos(switch_pos), .chr_latch(chr_latch),
        .cmd_we(cmd_we), .irq_we(irq_we), .inner_addr(inner_addr), .inner_data(inner_data)
    );

    function automatic logic [7:0] rg(input int i);
        return outer_regs[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; data = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic power_reset();
        @(negedge clk);
        pwr_rst_n = 1'b0;
        @(negedge clk);
        pwr_rst_n = 1'b1;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic t_reset();
        power_reset();
        chk("R1 regs", outer_regs, 64'hFFFFFFFF_00000000);
        chk("R1 switch", 64'(switch_pos), 64'd0);
        chk("R1 latch", 64'(chr_latch), 64'd0);
        chk("R1 strobes", 64'({cmd_we, irq_we}), 64'd0);
    endtask

    task automatic t_low_page();
        power_reset();
        bus_wr(16'h5010, 8'h11);
        chk("R3 reg0", 64'(rg(0)), 64'h11);
        bus_wr(16'h5012, 8'h33);
        chk("R3 reg2", 64'(rg(2)), 64'h33);
        bus_wr(16'h5001, 8'h99);
        chk("R3 gate bit clear", 64'(rg(1)), 64'h00);
        bus_wr(16'h6010, 8'h77);
        chk("R3 outside page", outer_regs, 64'hFFFFFFFF_00330011);
        chk("R3 outside no strobe", 64'({cmd_we, irq_we}), 64'd0);
    endtask

    task automatic t_soft_reset();
        power_reset();
        bus_wr(16'h5010, 8'h11);
        pulse_soft();
        chk("R2 step", 64'(switch_pos), 64'd1);
        chk("R2 regs init", outer_regs, 64'hFFFFFFFF_00000000);
        bus_wr(16'h5010, 8'h22);
        chk("R3 bit4 ignored at pos1", 64'(rg(0)), 64'h00);
        bus_wr(16'h5021, 8'h44);
        chk("R3 bit5 at pos1", 64'(rg(1)), 64'h44);
        for (int k = 0; k < 7; k++) pulse_soft();
        chk("R2 wrap", 64'(switch_pos), 64'd0);
    endtask

    task automatic t_variant();
        power_reset();
        variant_a = 1'b1;
        bus_wr(16'h5010, 8'h07);
        bus_wr(16'h5013, 8'h02);
        chk("R4 clear", 64'(rg(0)), 64'h00);
        chk("R4 reg3", 64'(rg(3)), 64'h02);
        bus_wr(16'h5010, 8'h05);
        chk("R4 clear again", 64'(rg(0)), 64'h00);
        variant_a = 1'b0;
        power_reset();
        bus_wr(16'h5010, 8'h07);
        bus_wr(16'h5013, 8'h02);
        chk("R4 no clear", 64'(rg(0)), 64'h07);
    endtask

    task automatic t_ext();
        // continues from t_variant: reg0=07, reg3=02
        inner_cmd = 8'h0A;
        bus_wr(16'h8001, 8'h5A);
        chk("R5 reg6", 64'(rg(6)), 64'h5A);
        chk("R5 no strobe", 64'({cmd_we, irq_we}), 64'd0);
        inner_cmd = 8'h0B;
        bus_wr(16'h8001, 8'hA5);
        chk("R5 reg7", 64'(rg(7)), 64'hA5);
        inner_cmd = 8'h02;
        bus_wr(16'h8001, 8'h3C);
        chk("R6 cmd bit3 clear", 64'({cmd_we, irq_we, inner_addr, inner_data}), {38'd0, 2'b10, 16'h8001, 8'h3C});
        chk("R5 reg6 kept", 64'(rg(6)), 64'h5A);
        inner_cmd = 8'h0A;
        bus_wr(16'h8000, 8'h06);
        chk("R6 not exact addr", 64'({cmd_we, irq_we, inner_data}), {54'd0, 2'b10, 8'h06});
    endtask

    task automatic t_ports();
        bus_wr(16'hA000, 8'h01);
        chk("R6 A000 cmd", 64'({cmd_we, irq_we, inner_addr}), {46'd0, 2'b10, 16'hA000});
        bus_wr(16'hC001, 8'h12);
        chk("R6 C001 irq", 64'({cmd_we, irq_we, inner_addr, inner_data}), {38'd0, 2'b01, 16'hC001, 8'h12});
        @(negedge clk);
        chk("R9 one cycle", 64'({cmd_we, irq_we}), 64'd0);
        bus_wr(16'hE000, 8'h00);
        chk("R6 E000 irq", 64'({cmd_we, irq_we}), 64'b01);
    endtask

    task automatic t_quirk();
        inner_cmd = 8'h00;
        chr_ram_board = 1'b1;
        bus_wr(16'h8000, 8'h46);
        chk("R7 46->47", 64'(inner_data), 64'h47);
        bus_wr(16'h8000, 8'h47);
        chk("R7 47->46", 64'(inner_data), 64'h46);
        bus_wr(16'h8000, 8'h45);
        chk("R7 other data", 64'(inner_data), 64'h45);
        bus_wr(16'h8001, 8'h46);
        chk("R7 other addr", 64'(inner_data), 64'h46);
        chr_ram_board = 1'b0;
        bus_wr(16'h8000, 8'h46);
        chk("R7 off", 64'(inner_data), 64'h46);
    endtask

    task automatic t_latch();
        power_reset();
        bus_wr(16'h5010, 8'h40);
        bus_wr(16'h8000, 8'h03);
        chk("R8 latch load", 64'(chr_latch), 64'd3);
        chk("R8 no strobe", 64'({cmd_we, irq_we}), 64'd0);
        bus_wr(16'hC000, 8'h02);
        chk("R8 high addr load", 64'({chr_latch, cmd_we, irq_we}), 64'b1000);
        bus_wr(16'h5010, 8'h50);
        bus_wr(16'h8000, 8'h03);
        chk("R8 bit4 forces 0", 64'({chr_latch, cmd_we, irq_we}), 64'd0);
        bus_wr(16'h5010, 8'h60);
        bus_wr(16'h8000, 8'h03);
        chk("R8 mode off forwards", 64'({chr_latch, cmd_we, irq_we}), 64'b0010);
    endtask

    initial begin
        t_reset();
        t_low_page();
        t_soft_reset();
        t_variant();
        t_ext();
        t_ports();
        t_quirk();
        t_latch();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule